// File: doc/BRIEF.md
# Floating-Point Issue Interlock Scoreboard

This block decides, in the same cycle that a floating-point operation is presented, whether that operation may issue. It tracks two execution units. One is a pipelined unit for add, multiply and convert operations. The other is an iterative unit for divide, square root, reciprocal and reciprocal square root. Each operation class has a result latency and a repeat interval, and both may depend on the precision flag. The block holds back a request for any of these reasons:
- its own unit has not reached its repeat interval yet;
- one of the source registers it reads still waits for an older result;
- its destination register still waits for an older result;
- its result would reach the single shared write port in a cycle that an older operation has already booked.

Work on the two units overlaps freely. A long divide does not block multiply or add traffic.

The issue stage drives a request strobe together with the class, the precision and the register numbers. It advances when a grant is returned and holds the same operation while a stall is returned. On a grant, the block also reports how many cycles remain until the destination is written. The arithmetic itself, rounding and exceptions lie outside the block. The reset input is asynchronous. Internally, its release is taken through two flops, so requests are honoured from the second clock edge after reset is released.

Top module: `fp_issue_sb`

## Requirements
- R1: After reset both units are idle (`mad_busy`=0, `dsq_busy`=0), every register is ready, and the first request is granted.
- R2: The `op_class` codes are: 0 add, 1 sub, 2 mul, 3 mul-add, 4 mul-sub, 9 convert integer to single, 10 any other convert, 11 compare, 12 move, 13 conditional move, 14 abs, 15 neg. All of these run on the pipelined unit. Their latency and repeat, in cycles, are:
  - add and sub: 4/1.
  - mul, mul-add, mul-sub: 4/1 with `dbl`=0, and 5/2 with `dbl`=1.
  - code 9: 6/3.
  - code 10: 4/1.
  - codes 11 to 15: 1/1.
  
  `wb_lat` shows the latency in the cycle of a grant and is 0 otherwise.
- R3: The `op_class` codes 5 divide, 6 square root, 7 reciprocal and 8 reciprocal square root run on the iterative unit. Codes 5 to 7 take 21/19 single and 36/34 double. Code 8 takes 38/36 single and 68/66 double.
- R4: An operation is stalled while any register it reads has a result outstanding. An operation granted in cycle t with latency L makes its destination readable from cycle t+L. The registers read depend on the class:
  - mul-add and mul-sub read `src_a`, `src_b` and `src_c`.
  - codes 6, 7, 8, 9, 10, 12, 14 and 15 read only `src_a`.
  - every other code reads `src_a` and `src_b`.
- R5: After a grant with repeat interval P, the same unit takes no new operation for P-1 cycles. `mad_busy` and `dsq_busy` are 1 exactly during those blocked cycles.
- R6: A busy iterative unit does not hold back pipelined-unit operations, and the reverse is also true.
- R7: Both units share one write port. A request whose writeback would land in a cycle already booked by an earlier grant is stalled, and it is granted as soon as its own slot is free.
- R8: An operation whose destination register still has a result outstanding is stalled.
- R9: `stall` is 1 exactly when `req_valid` is 1 and `grant` is 0. Without a request, neither `grant` nor `stall` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An operation is presented for issue |
| op_class | input | 4 | Operation class code (R2, R3) |
| dbl | input | 1 | 1 = double precision, 0 = single |
| src_a | input | 5 | First source register |
| src_b | input | 5 | Second source register |
| src_c | input | 5 | Third source register (fused ops) |
| dst | input | 5 | Destination register |
| grant | output | 1 | Operation issues this cycle |
| stall | output | 1 | Operation presented but held |
| mad_busy | output | 1 | Pipelined unit inside its repeat interval |
| dsq_busy | output | 1 | Iterative unit inside its repeat interval |
| wb_lat | output | 7 | Cycles from issue to writeback of the granted op |

## Verification
Two completions can fall on the same write-port cycle. A result from the iterative unit, booked many cycles earlier, can meet a short pipelined operation issued later. Two pipelined operations with different latencies can also meet. The bench sets both cases up on purpose. It issues a single-precision divide, then after a known count of idle cycles it presents an add whose four-cycle latency points at the divide's writeback cycle. The add must be stalled for exactly one cycle and then granted. A one-cycle negate is then aimed at the add's own writeback slot. In each case the expected grant and the `wb_lat` value are computed from the latency rules of the requirements, not from the design.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

  localparam int LAT_W   = 7;
  localparam int MAX_LAT = 68;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,  OP_SUB   = 4'd1,  OP_MUL  = 4'd2,  OP_MADD = 4'd3,
    OP_MSUB  = 4'd4,  OP_DIV   = 4'd5,  OP_SQRT = 4'd6,  OP_RCP  = 4'd7,
    OP_RSQRT = 4'd8,  OP_CVTIS = 4'd9,  OP_CVT  = 4'd10, OP_CMP  = 4'd11,
    OP_MOV   = 4'd12, OP_MOVC  = 4'd13, OP_ABS  = 4'd14, OP_NEG  = 4'd15
  } fp_op_e;

  typedef enum logic {UNIT_MAD = 1'b0, UNIT_DSQ = 1'b1} fp_unit_e;

  typedef struct packed {
    logic [LAT_W-1:0] lat;
    logic [LAT_W-1:0] rep;
    fp_unit_e         unit;
    logic [2:0]       rd_use;  // bit0 src_a, bit1 src_b, bit2 src_c
  } op_timing_t;

  function automatic op_timing_t op_timing(fp_op_e op, logic dbl);
    op_timing_t t;
    t.lat    = LAT_W'(4);
    t.rep    = LAT_W'(1);
    t.unit   = UNIT_MAD;
    t.rd_use = 3'b011;
    case (op)
      OP_ADD, OP_SUB: ;
      OP_MUL, OP_MADD, OP_MSUB: begin
        t.lat = dbl ? LAT_W'(5) : LAT_W'(4);
        t.rep = dbl ? LAT_W'(2) : LAT_W'(1);
        if (op != OP_MUL) t.rd_use = 3'b111;
      end
      OP_DIV, OP_SQRT, OP_RCP: begin
        t.unit = UNIT_DSQ;
        t.lat  = dbl ? LAT_W'(36) : LAT_W'(21);
        t.rep  = dbl ? LAT_W'(34) : LAT_W'(19);
        if (op != OP_DIV) t.rd_use = 3'b001;
      end
      OP_RSQRT: begin
        t.unit   = UNIT_DSQ;
        t.lat    = dbl ? LAT_W'(68) : LAT_W'(38);
        t.rep    = dbl ? LAT_W'(66) : LAT_W'(36);
        t.rd_use = 3'b001;
      end
      OP_CVTIS: begin
        t.lat    = LAT_W'(6);
        t.rep    = LAT_W'(3);
        t.rd_use = 3'b001;
      end
      OP_CVT: t.rd_use = 3'b001;
      OP_CMP, OP_MOVC: t.lat = LAT_W'(1);
      OP_MOV, OP_ABS, OP_NEG: begin
        t.lat    = LAT_W'(1);
        t.rd_use = 3'b001;
      end
      default: ;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/fpsb_reg_track.sv
module fpsb_reg_track #(
  parameter int NREG  = 32,
  parameter int CNT_W = 7,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rd_a,
  input  logic [REG_W-1:0] rd_b,
  input  logic [REG_W-1:0] rd_c,
  input  logic [2:0]       rd_use,
  input  logic [REG_W-1:0] wr_reg,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             src_busy,
  output logic             dst_busy
);

  logic [CNT_W-1:0] cnt_q [NREG];
  logic [CNT_W-1:0] cnt_d [NREG];
  logic [NREG-1:0]  cnt_en;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_comb begin
      cnt_en[r] = 1'b0;
      cnt_d[r]  = cnt_q[r];
      if (load_en && wr_reg == REG_W'(r)) begin
        cnt_en[r] = 1'b1;
        cnt_d[r]  = load_val;
      end else if (cnt_q[r] != '0) begin
        cnt_en[r] = 1'b1;
        cnt_d[r]  = cnt_q[r] - CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q[r] <= '0;
      else if (cnt_en[r])  cnt_q[r] <= cnt_d[r];
    end
  end

  always_comb begin
    src_busy = (rd_use[0] && cnt_q[rd_a] != '0) ||
               (rd_use[1] && cnt_q[rd_b] != '0) ||
               (rd_use[2] && cnt_q[rd_c] != '0);
    dst_busy = (cnt_q[wr_reg] != '0);
  end

endmodule

// File: rtl/fpsb_unit_gate.sv
module fpsb_unit_gate #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  output logic             busy
);

  logic [CNT_W-1:0] gap_q, gap_d;
  logic             gap_en;

  always_comb begin
    gap_en = 1'b0;
    gap_d  = gap_q;
    if (start) begin
      gap_en = 1'b1;
      gap_d  = reload;
    end else if (gap_q != '0) begin
      gap_en = 1'b1;
      gap_d  = gap_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  assign busy = (gap_q != '0);

endmodule

// File: rtl/fpsb_wb_sched.sv
module fpsb_wb_sched #(
  parameter int MAX_LAT = 68,
  parameter int LAT_W   = 7,
  localparam int DEPTH  = MAX_LAT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] probe_lat,
  input  logic             book,
  output logic             clash
);

  logic [DEPTH-1:0] slot_q, slot_d, slot_new;

  always_comb begin
    clash    = slot_q[probe_lat];
    slot_new = DEPTH'(1) << (probe_lat - LAT_W'(1));
    slot_d   = slot_q >> 1;
    if (book) slot_d = slot_d | slot_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

endmodule

// File: rtl/fp_issue_sb.sv
module fp_issue_sb
  import fpsb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       op_class,
  input  logic             dbl,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] src_c,
  input  logic [REG_W-1:0] dst,
  output logic             grant,
  output logic             stall,
  output logic             mad_busy,
  output logic             dsq_busy,
  output logic [LAT_W-1:0] wb_lat
);

  localparam int NUNIT = 2;

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  op_timing_t       tm;
  logic             src_busy, dst_busy, wb_clash, unit_block;
  logic [NUNIT-1:0] unit_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign tm = op_timing(fp_op_e'(op_class), dbl);

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    fpsb_unit_gate #(.CNT_W(LAT_W)) u_gate (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .start  (grant && tm.unit == fp_unit_e'(u)),
      .reload (tm.rep - LAT_W'(1)),
      .busy   (unit_busy[u])
    );
  end

  fpsb_reg_track #(.NREG(NREG), .CNT_W(LAT_W)) u_regs (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_a     (src_a),
    .rd_b     (src_b),
    .rd_c     (src_c),
    .rd_use   (tm.rd_use),
    .wr_reg   (dst),
    .load_en  (grant),
    .load_val (tm.lat - LAT_W'(1)),
    .src_busy (src_busy),
    .dst_busy (dst_busy)
  );

  fpsb_wb_sched #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_wb (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .probe_lat (tm.lat),
    .book      (grant),
    .clash     (wb_clash)
  );

  always_comb begin
    unit_block = unit_busy[tm.unit];
    grant      = req_valid && core_rst_n && !src_busy && !dst_busy &&
                 !unit_block && !wb_clash;
    stall      = req_valid && !grant;
    wb_lat     = grant ? tm.lat : '0;
  end

  assign mad_busy = unit_busy[UNIT_MAD];
  assign dsq_busy = unit_busy[UNIT_DSQ];

endmodule

// File: rtl/fp_issue_sb_chk.sv
module fp_issue_sb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] op_class,
  input logic       dbl,
  input logic       grant,
  input logic       stall,
  input logic       mad_busy,
  input logic       dsq_busy,
  input logic [6:0] wb_lat
);

  logic is_dsq, is_mul;
  assign is_dsq = (op_class >= 4'd5) && (op_class <= 4'd8);
  assign is_mul = (op_class >= 4'd2) && (op_class <= 4'd4);

  AST_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (grant != stall));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !stall));  // R9
  AST_WB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> (wb_lat == 7'd0));  // R2
  AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (wb_lat != 7'd0));  // R2
  AST_DSQ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (dsq_busy && req_valid && is_dsq) |-> !grant);  // R5
  AST_DSQ_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && is_dsq) |=> dsq_busy);  // R3
  AST_MULD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && dbl && is_mul) |=> mad_busy);  // R2

endmodule

bind fp_issue_sb fp_issue_sb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .op_class  (op_class),
  .dbl       (dbl),
  .grant     (grant),
  .stall     (stall),
  .mad_busy  (mad_busy),
  .dsq_busy  (dsq_busy),
  .wb_lat    (wb_lat)
);

// File: tb/fp_issue_sb_tb.sv
module fp_issue_sb_tb;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] op_class;
  logic       dbl;
  logic [4:0] src_a, src_b, src_c, dst;
  logic       grant, stall, mad_busy, dsq_busy;
  logic [6:0] wb_lat;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic       req;
    logic [3:0] op;
    logic       dp;
    logic [4:0] a;
    logic [4:0] b;
    logic [4:0] c;
    logic [4:0] d;
    logic       g;
    logic [6:0] wb;
  } vec_t;

  // Cycle-by-cycle sequence from reset; state carries between rows.
  localparam vec_t VEC [12] = '{
    '{1'b1, 4'd0, 1'b0, 5'd1,  5'd2, 5'd0,  5'd10, 1'b1, 7'd4 },  // R2 add
    '{1'b1, 4'd0, 1'b0, 5'd10, 5'd2, 5'd0,  5'd11, 1'b0, 7'd0 },  // R4 raw
    '{1'b1, 4'd0, 1'b0, 5'd10, 5'd2, 5'd0,  5'd11, 1'b0, 7'd0 },  // R4
    '{1'b1, 4'd0, 1'b0, 5'd10, 5'd2, 5'd0,  5'd11, 1'b0, 7'd0 },  // R4
    '{1'b1, 4'd0, 1'b0, 5'd10, 5'd2, 5'd0,  5'd11, 1'b1, 7'd4 },  // R4 release
    '{1'b1, 4'd2, 1'b1, 5'd3,  5'd4, 5'd0,  5'd12, 1'b1, 7'd5 },  // R2 mul dbl
    '{1'b1, 4'd0, 1'b0, 5'd1,  5'd2, 5'd0,  5'd13, 1'b0, 7'd0 },  // R5 gap
    '{1'b1, 4'd0, 1'b0, 5'd1,  5'd2, 5'd0,  5'd13, 1'b1, 7'd4 },  // R5
    '{1'b1, 4'd5, 1'b0, 5'd1,  5'd2, 5'd0,  5'd14, 1'b1, 7'd21},  // R3 div
    '{1'b1, 4'd2, 1'b0, 5'd1,  5'd2, 5'd0,  5'd15, 1'b1, 7'd4 },  // R6 overlap
    '{1'b1, 4'd3, 1'b0, 5'd1,  5'd2, 5'd13, 5'd18, 1'b0, 7'd0 },  // R4 src_c
    '{1'b1, 4'd6, 1'b0, 5'd5,  5'd0, 5'd0,  5'd16, 1'b0, 7'd0 }   // R5 dsq busy
  };

  fp_issue_sb u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op_class  (op_class),
    .dbl       (dbl),
    .src_a     (src_a),
    .src_b     (src_b),
    .src_c     (src_c),
    .dst       (dst),
    .grant     (grant),
    .stall     (stall),
    .mad_busy  (mad_busy),
    .dsq_busy  (dsq_busy),
    .wb_lat    (wb_lat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic drive(input logic r, input logic [3:0] op, input logic dp,
                       input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] c, input logic [4:0] d);
    req_valid = r; op_class = op; dbl = dp;
    src_a = a; src_b = b; src_c = c; dst = d;
  endtask

  // Drive just after an edge, judge before the next edge, then advance.
  task automatic cyc(input string tag, input logic r, input logic [3:0] op,
                     input logic dp, input logic [4:0] a, input logic [4:0] b,
                     input logic [4:0] c, input logic [4:0] d,
                     input logic eg, input int ewb);
    drive(r, op, dp, a, b, c, d);
    #4;
    chk({tag, " grant"}, int'(grant), int'(eg));
    chk({tag, " stall"}, int'(stall), int'(r && !eg));
    chk({tag, " wb_lat"}, int'(wb_lat), ewb);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 4'd0, 1'b0, 5'd0, 5'd0, 5'd0, 5'd0);
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset();
    drive(1'b0, 4'd0, 1'b0, 5'd0, 5'd0, 5'd0, 5'd0);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    #4;
    chk("R1 mad_busy", int'(mad_busy), 0);
    chk("R1 dsq_busy", int'(dsq_busy), 0);
    chk("R1 idle grant", int'(grant), 0);
    @(posedge clk); #1;

    // Vector walk: t0..t11
    for (int k = 0; k < 12; k++) begin
      cyc($sformatf("vec%0d", k), VEC[k].req, VEC[k].op, VEC[k].dp,
          VEC[k].a, VEC[k].b, VEC[k].c, VEC[k].d, VEC[k].g, int'(VEC[k].wb));
    end

    // t12..t24 idle; divide (t8, lat 21) books t29
    idle(13);
    // t25: add lat 4 aims at t29 -> write-port clash, R7
    cyc("R7 clash", 1'b1, 4'd0, 1'b0, 5'd1, 5'd2, 5'd0, 5'd17, 1'b0, 0);
    // t26: slot t30 free, R7 retry; iterative unit still in gap, R5
    drive(1'b1, 4'd0, 1'b0, 5'd1, 5'd2, 5'd0, 5'd17);
    #4;
    chk("R5 dsq_busy last gap cycle", int'(dsq_busy), 1);
    chk("R7 retry grant", int'(grant), 1);
    chk("R7 retry wb_lat", int'(wb_lat), 4);
    @(posedge clk); #1;
    // t27: gap ended, sqrt issues, R3
    cyc("R3 sqrt", 1'b1, 4'd6, 1'b0, 5'd5, 5'd0, 5'd0, 5'd16, 1'b1, 21);
    // t28: same destination pending, R8
    cyc("R8 waw", 1'b1, 4'd0, 1'b0, 5'd1, 5'd2, 5'd0, 5'd16, 1'b0, 0);
    // t29: neg lat 1 aims at t30 booked by add, R7
    cyc("R7 short clash", 1'b1, 4'd15, 1'b0, 5'd14, 5'd0, 5'd0, 5'd19, 1'b0, 0);
    // t30: R2 neg, R4 divide result now readable
    cyc("R2 neg", 1'b1, 4'd15, 1'b0, 5'd14, 5'd0, 5'd0, 5'd19, 1'b1, 1);

    // Second run: convert gap, one-cycle ops, source usage
    do_reset();
    cyc("R2 cvt int->s", 1'b1, 4'd9, 1'b0, 5'd1, 5'd0, 5'd0, 5'd20, 1'b1, 6);
    drive(1'b1, 4'd11, 1'b0, 5'd1, 5'd2, 5'd0, 5'd21);
    #4;
    chk("R5 mad_busy", int'(mad_busy), 1);
    chk("R5 cmp gap", int'(grant), 0);
    @(posedge clk); #1;
    cyc("R5 cmp gap2", 1'b1, 4'd11, 1'b0, 5'd1, 5'd2, 5'd0, 5'd21, 1'b0, 0);
    cyc("R2 cmp", 1'b1, 4'd11, 1'b0, 5'd1, 5'd2, 5'd0, 5'd21, 1'b1, 1);
    // abs reads only src_a; src_b=20 still pending must not matter, R4
    cyc("R4 abs ignores src_b", 1'b1, 4'd14, 1'b0, 5'd21, 5'd20, 5'd0, 5'd22,
        1'b1, 1);
    cyc("R3 rsqrt dbl", 1'b1, 4'd8, 1'b1, 5'd1, 5'd0, 5'd0, 5'd23, 1'b1, 68);
    cyc("R5 div during rsqrt", 1'b1, 4'd5, 1'b1, 5'd1, 5'd2, 5'd0, 5'd24,
        1'b0, 0);
    cyc("R6 add during rsqrt", 1'b1, 4'd1, 1'b0, 5'd1, 5'd2, 5'd0, 5'd25,
        1'b1, 4);

    // Third run: double divide, reciprocal single
    do_reset();
    cyc("R3 div dbl", 1'b1, 4'd5, 1'b1, 5'd1, 5'd2, 5'd0, 5'd26, 1'b1, 36);
    do_reset();
    cyc("R3 recip s", 1'b1, 4'd7, 1'b0, 5'd1, 5'd0, 5'd0, 5'd27, 1'b1, 21);
    cyc("R9 no request", 1'b0, 4'd0, 1'b0, 5'd1, 5'd2, 5'd0, 5'd28, 1'b0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule